// File: doc/BRIEF.md
# Dual-Set Receive DMA Ring Engine

This block moves received Ethernet frames from a byte-wide receive stream into memory buffers of fixed size, with one frame per buffer. Each buffer begins with a 16-byte header that the engine fills in once the frame has ended. The payload follows from byte 16 onward. Memory is reached through a plain byte-write port.

Software programs two register sets over a small register bus. Each set holds a base address, a remaining-buffer count and a command word. The engine fills buffers from the active set only. When the last buffer of that set is used, the engine reloads the set to a full count, disarms it and moves on to the other set. Software arms a set again after it has drained that set's buffers.

The interrupt output is level-sensitive. It stays high while either set has an unacknowledged done state, or while a stream error waits for a channel reset.

Top module: `rx_ring_dma`

## Requirements
- R1: Register offsets. Set s (s = 0 or 1) is at s*0x10: base at +0x0, remaining count at +0x4, command at +0x8. Control/status is at 0x20 and the missed-frame counter is at 0x24. Reads of base and count return the last value written.
- R2: Command values written to a set's command register:
  - 0x9800 arms the set.
  - 0x1100 stops the set.
  - 0x0100 clears the set's done state.
  - Any other value has no effect.
  
  A read of the command register returns bit 15 = armed and bit 8 = done.
- R3: Byte k of a frame is written to base + idx*2048 + 16 + k, where idx = 8 - remaining. Each byte appears on the memory port one clock edge after the beat that carries it.
- R4: The header is written in four consecutive cycles, starting one edge after the end-of-frame beat:
  - byte 0: stored length bits [7:0];
  - byte 2: {overflow, collision, framing, FCS, length[11:8]}, with overflow in bit 7;
  - byte 4: the runt count;
  - byte 6: the collision count.
- R5: The remaining count of the active set drops by one for each completed frame, so 8 - remaining is the index of the next buffer to be filled.
- R6: Completing the buffer where the remaining count was 1 has three effects:
  - the set reloads to 8 and disarms;
  - the active set toggles;
  - status bit 0 shows which set is now active.
- R7: A frame longer than 2032 bytes stores only its first 2032 bytes, reports a stored length of 2032, and sets the overflow bit in its header.
- R8: A frame that starts while the active set is not armed writes nothing to memory and adds one to the missed-frame counter.
- R9: The done state of the active set is set on the cycle of the last header write. The irq output is high while any done state or the error is set, and falls once every done state is cleared.
- R10: Two events are stream errors:
  - a start-of-frame beat in the middle of a frame;
  - any receive beat while the header is being written.
  
  A stream error sets status bit 13 and raises irq. The interrupted frame gets no header and its buffer is not consumed. Later frames are ignored and are not counted as missed.
- R11: A write to 0x20 with bit 15 set resets the channel. It clears the error, both done states and both armed states, and selects set 0. Base and count values are kept.
- R12: After reset, every register reads zero, irq is low and the memory port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| rx_valid | input | 1 | Receive beat valid |
| rx_sof | input | 1 | First beat of a frame |
| rx_eof | input | 1 | Last beat of a frame |
| rx_data | input | 8 | Received byte |
| rx_flags | input | 3 | Frame flags {collision, framing, FCS}, sampled on the last beat |
| rx_runt | input | 8 | Runt count, sampled on the last beat |
| rx_coll | input | 8 | Collision count, sampled on the last beat |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| irq | output | 1 | Level interrupt |

## Verification
Every memory write is expected on the edge after the receive beat that causes it. The four header bytes are expected on the four edges after the end-of-frame beat, and done and irq rise together with the last of those header bytes. The bench queues each expected address/data pair before it drives the frame. A monitor sampling on the falling edge pops one queued entry for each write and flags any write it did not expect. Register reads are combinational and command effects land on the next edge, so every register check and irq check is made at a falling edge at least six cycles after the last beat of a frame.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_HDR  = 2'd2
  } rx_state_e;

  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;
  localparam logic [15:0] CMD_ACK  = 16'h0100;

  localparam int LEN_W = 12;
endpackage

// File: rtl/rx_ring_set.sv
module rx_ring_set
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RING_BUFS = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              wr_base,
  input  logic              wr_len,
  input  logic              wr_cmd,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              frame_done,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  rem,
  output logic              armed,
  output logic              done
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RING_BUFS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] base_n;
  logic [CNT_W-1:0]  rem_n;
  logic              armed_n, done_n;
  logic [15:0]       cmd;

  assign cmd = wdata[15:0];

  always_comb begin
    base_n  = base;
    rem_n   = rem;
    armed_n = armed;
    done_n  = done;
    if (wr_base) base_n = wdata;
    if (wr_len) rem_n = wdata[CNT_W-1:0];
    else if (frame_done) rem_n = (rem == ONE) ? FULL : rem - ONE;
    if (frame_done) begin
      done_n = 1'b1;
      if (rem == ONE) armed_n = 1'b0;
    end
    if (wr_cmd) begin
      if (cmd == CMD_ARM) armed_n = 1'b1;
      else if (cmd == CMD_STOP) armed_n = 1'b0;
      else if (cmd == CMD_ACK && !frame_done) done_n = 1'b0;
    end
    if (chan_rst) begin
      armed_n = 1'b0;
      done_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      rem   <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else begin
      base  <= base_n;
      rem   <= rem_n;
      armed <= armed_n;
      done  <= done_n;
    end
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !chan_rst) |=> done); // R9

  AST_LAST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rem == ONE && !chan_rst && !wr_len && !(wr_cmd && cmd == CMD_ARM))
      |=> (!armed && rem == FULL)); // R6
endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 2048,
  parameter int HDR_BYTES = 16,
  parameter int RING_BUFS = 8,
  parameter int CNT_W     = 4,
  parameter int MISS_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [2:0]        rx_flags,
  input  logic [7:0]        rx_runt,
  input  logic [7:0]        rx_coll,
  input  logic [ADDR_W-1:0] act_base,
  input  logic [CNT_W-1:0]  act_rem,
  input  logic              act_armed,
  output logic              frame_done,
  output logic              act,
  output logic              err,
  output logic [MISS_W-1:0] missed,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int               BUF_SHIFT = $clog2(BUF_BYTES);
  localparam int               CAP       = BUF_BYTES - HDR_BYTES;
  localparam logic [LEN_W-1:0] CAP_L     = LEN_W'(CAP);
  localparam logic [ADDR_W-1:0] HDR_OFF  = ADDR_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  rx_state_e         st, st_n;
  logic [ADDR_W-1:0] buf_addr, buf_n, slot_addr;
  logic [CNT_W-1:0]  idx;
  logic [LEN_W-1:0]  flen, flen_n;
  logic              ovf, ovf_n;
  logic [2:0]        flg, flg_n;
  logic [7:0]        runt_q, runt_n, coll_q, coll_n;
  logic [1:0]        hstep, hstep_n;
  logic              err_n, act_n;
  logic [MISS_W-1:0] miss_n;
  logic              we_n;
  logic [ADDR_W-1:0] addr_n;
  logic [7:0]        wd_n;

  assign idx       = CNT_W'(RING_BUFS) - act_rem;
  assign slot_addr = act_base + (ADDR_W'(idx) << BUF_SHIFT);
  assign frame_done = (st == ST_HDR) && (hstep == 2'd3) && !chan_rst;

  always_comb begin
    st_n    = st;
    buf_n   = buf_addr;
    flen_n  = flen;
    ovf_n   = ovf;
    flg_n   = flg;
    runt_n  = runt_q;
    coll_n  = coll_q;
    hstep_n = hstep;
    err_n   = err;
    act_n   = act;
    miss_n  = missed;
    we_n    = 1'b0;
    addr_n  = mem_addr;
    wd_n    = mem_wdata;
    if (chan_rst) begin
      st_n    = ST_IDLE;
      err_n   = 1'b0;
      act_n   = 1'b0;
      hstep_n = 2'd0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rx_valid && rx_sof && !err) begin
            if (act_armed && act_rem != '0) begin
              buf_n  = slot_addr;
              we_n   = 1'b1;
              addr_n = slot_addr + HDR_OFF;
              wd_n   = rx_data;
              flen_n = LEN_W'(1);
              ovf_n  = 1'b0;
              if (rx_eof) begin
                flg_n   = rx_flags;
                runt_n  = rx_runt;
                coll_n  = rx_coll;
                hstep_n = 2'd0;
                st_n    = ST_HDR;
              end else begin
                st_n = ST_DATA;
              end
            end else begin
              miss_n = missed + MISS_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (rx_valid) begin
            if (rx_sof) begin
              err_n = 1'b1;
              st_n  = ST_IDLE;
            end else begin
              if (flen < CAP_L) begin
                we_n   = 1'b1;
                addr_n = buf_addr + HDR_OFF + ADDR_W'(flen);
                wd_n   = rx_data;
                flen_n = flen + LEN_W'(1);
              end else begin
                ovf_n = 1'b1;
              end
              if (rx_eof) begin
                flg_n   = rx_flags;
                runt_n  = rx_runt;
                coll_n  = rx_coll;
                hstep_n = 2'd0;
                st_n    = ST_HDR;
              end
            end
          end
        end
        ST_HDR: begin
          we_n   = 1'b1;
          addr_n = buf_addr + ADDR_W'({hstep, 1'b0});
          case (hstep)
            2'd0:    wd_n = flen[7:0];
            2'd1:    wd_n = {ovf, flg, flen[11:8]};
            2'd2:    wd_n = runt_q;
            default: wd_n = coll_q;
          endcase
          hstep_n = hstep + 2'd1;
          if (hstep == 2'd3) begin
            st_n = ST_IDLE;
            if (act_rem == ONE) act_n = ~act;
          end
          if (rx_valid) err_n = 1'b1;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      buf_addr  <= '0;
      flen      <= '0;
      ovf       <= 1'b0;
      flg       <= '0;
      runt_q    <= '0;
      coll_q    <= '0;
      hstep     <= '0;
      err       <= 1'b0;
      act       <= 1'b0;
      missed    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      st        <= st_n;
      buf_addr  <= buf_n;
      flen      <= flen_n;
      ovf       <= ovf_n;
      flg       <= flg_n;
      runt_q    <= runt_n;
      coll_q    <= coll_n;
      hstep     <= hstep_n;
      err       <= err_n;
      act       <= act_n;
      missed    <= miss_n;
      mem_we    <= we_n;
      mem_addr  <= addr_n;
      mem_wdata <= wd_n;
    end
  end

  AST_HDR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR && !chan_rst) |=> mem_we); // R4

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (err && st == ST_IDLE) |=> !mem_we); // R10

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    flen <= CAP_L); // R7

  AST_SET_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && act_rem == ONE) |=> (act != $past(act))); // R6
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 2048,
  parameter int HDR_BYTES = 16,
  parameter int RING_BUFS = 8,
  parameter int MISS_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic [2:0]        rx_flags,
  input  logic [7:0]        rx_runt,
  input  logic [7:0]        rx_coll,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              irq
);
  localparam int NSETS = 2;
  localparam int CNT_W = $clog2(RING_BUFS + 1);

  logic [ADDR_W-1:0] base_a  [NSETS];
  logic [CNT_W-1:0]  rem_a   [NSETS];
  logic              armed_a [NSETS];
  logic              done_a  [NSETS];
  logic              fdone_a [NSETS];
  logic              frame_done, act, err, chan_rst;
  logic [MISS_W-1:0] missed;
  logic              sel;

  assign chan_rst = reg_we && (reg_addr == 6'h20) && reg_wdata[15];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic wr_b, wr_l, wr_c;
    assign wr_b = reg_we && (reg_addr[5:4] == 2'(s)) && (reg_addr[3:0] == 4'h0);
    assign wr_l = reg_we && (reg_addr[5:4] == 2'(s)) && (reg_addr[3:0] == 4'h4);
    assign wr_c = reg_we && (reg_addr[5:4] == 2'(s)) && (reg_addr[3:0] == 4'h8);
    assign fdone_a[s] = frame_done && (act == 1'(s));

    rx_ring_set #(
      .ADDR_W   (ADDR_W),
      .RING_BUFS(RING_BUFS),
      .CNT_W    (CNT_W)
    ) u_set (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_rst  (chan_rst),
      .wr_base   (wr_b),
      .wr_len    (wr_l),
      .wr_cmd    (wr_c),
      .wdata     (reg_wdata[ADDR_W-1:0]),
      .frame_done(fdone_a[s]),
      .base      (base_a[s]),
      .rem       (rem_a[s]),
      .armed     (armed_a[s]),
      .done      (done_a[s])
    );
  end

  rx_ring_fsm #(
    .ADDR_W   (ADDR_W),
    .BUF_BYTES(BUF_BYTES),
    .HDR_BYTES(HDR_BYTES),
    .RING_BUFS(RING_BUFS),
    .CNT_W    (CNT_W),
    .MISS_W   (MISS_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_rst  (chan_rst),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .rx_data   (rx_data),
    .rx_flags  (rx_flags),
    .rx_runt   (rx_runt),
    .rx_coll   (rx_coll),
    .act_base  (base_a[act]),
    .act_rem   (rem_a[act]),
    .act_armed (armed_a[act]),
    .frame_done(frame_done),
    .act       (act),
    .err       (err),
    .missed    (missed),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign sel = reg_addr[4];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[5] == 1'b0) begin
      case (reg_addr[3:0])
        4'h0: reg_rdata[ADDR_W-1:0] = base_a[sel];
        4'h4: reg_rdata[CNT_W-1:0]  = rem_a[sel];
        4'h8: begin
          reg_rdata[15] = armed_a[sel];
          reg_rdata[8]  = done_a[sel];
        end
        default: reg_rdata = '0;
      endcase
    end else if (reg_addr[4] == 1'b0) begin
      case (reg_addr[3:0])
        4'h0: begin
          reg_rdata[13] = err;
          reg_rdata[8]  = done_a[0] | done_a[1];
          reg_rdata[0]  = act;
        end
        4'h4: reg_rdata[MISS_W-1:0] = missed;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq = done_a[0] | done_a[1] | err;
endmodule

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 2032;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data, rx_runt, rx_coll;
  logic [2:0]  rx_flags;
  logic        mem_we, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;

  int tests = 0;
  int fails = 0;

  logic [31:0] exp_addr[$];
  logic [7:0]  exp_data[$];
  string       exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .rx_flags(rx_flags),
    .rx_runt(rx_runt), .rx_coll(rx_coll), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected write per observed memory write
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      if (exp_addr.size() == 0) begin
        check("unexpected write (R8/R10)", mem_addr, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea;
        logic [7:0]  ed;
        string       et;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        et = exp_tag.pop_front();
        check({et, " addr"}, mem_addr, ea);
        check({et, " data"}, {24'd0, mem_wdata}, {24'd0, ed});
      end
    end
  end

  task automatic push(input logic [31:0] a, input logic [7:0] d, input string t);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_tag.push_back(t);
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  // drives one frame; when expect_store, queues the data and header writes
  task automatic send_frame(input int n, input logic [2:0] fl, input logic [7:0] runt,
                            input logic [7:0] coll, input logic [31:0] bufa,
                            input logic [7:0] seed, input bit expect_store);
    int   stored;
    logic ovf;
    stored = (n > CAP) ? CAP : n;
    ovf    = (n > CAP);
    if (expect_store) begin
      for (int k = 0; k < stored; k++)
        push(bufa + 32'd16 + 32'(k), seed + 8'(k * 7), (n > CAP) ? "R7 payload" : "R3 payload");
      push(bufa,         8'(stored), "R4 len_lo");
      push(bufa + 32'd2, {ovf, fl, 4'(stored >> 8)}, ovf ? "R7 status" : "R4 status");
      push(bufa + 32'd4, runt, "R4 runt");
      push(bufa + 32'd6, coll, "R4 coll");
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_eof = (k == n - 1);
      rx_data = seed + 8'(k * 7); rx_flags = fl; rx_runt = runt; rx_coll = coll;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    rx_flags = '0; rx_runt = '0; rx_coll = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    @(negedge clk);
    check("R12 irq", {31'd0, irq}, 32'd0);
    check("R12 mem_we", {31'd0, mem_we}, 32'd0);
    reg_check(6'h20, 32'h0, "R12 status");
    reg_check(6'h24, 32'h0, "R12 missed");
    reg_check(6'h08, 32'h0, "R12 cmd0");
    reg_check(6'h14, 32'h0, "R12 len1");

    // R1 programming
    reg_write(6'h00, 32'h0000_0000);
    reg_write(6'h04, 32'd8);
    reg_write(6'h10, 32'h0000_4000);
    reg_write(6'h14, 32'd8);
    reg_check(6'h10, 32'h4000, "R1 base1");
    reg_check(6'h04, 32'd8, "R1 len0");

    // R2 commands
    reg_write(6'h08, 32'h0000_1234);
    reg_check(6'h08, 32'h0, "R2 ignored value");
    reg_write(6'h08, 32'h0000_9800);
    reg_check(6'h08, 32'h8000, "R2 arm");

    // R3/R4 first frame, buffer 0
    send_frame(20, 3'b000, 8'd3, 8'd1, 32'h0000, 8'h01, 1'b1);
    check("R9 irq after frame", {31'd0, irq}, 32'd1);
    reg_check(6'h04, 32'd7, "R5 remaining");
    reg_check(6'h08, 32'h8100, "R2 done+armed");
    reg_write(6'h08, 32'h0000_0100);
    check("R9 irq after ack", {31'd0, irq}, 32'd0);

    // R4 single-beat frame with flags, buffer 1
    send_frame(1, 3'b101, 8'd0, 8'd2, 32'h0800, 8'h40, 1'b1);
    reg_write(6'h08, 32'h0000_0100);

    // R7 oversize frame, buffer 2
    send_frame(2040, 3'b000, 8'd5, 8'd0, 32'h1000, 8'h11, 1'b1);
    reg_write(6'h08, 32'h0000_0100);
    reg_check(6'h04, 32'd5, "R5 remaining after 3");

    // fill remaining buffers 3..7
    for (int i = 3; i < 8; i++) begin
      send_frame(5 + i, 3'b010, 8'(i), 8'(i + 1), 32'(i) * 32'h800, 8'(i * 3), 1'b1);
    end
    reg_check(6'h04, 32'd8, "R6 reload");
    reg_check(6'h08, 32'h0100, "R6 disarmed");
    reg_check(6'h20, 32'h0101, "R6 active set 1");
    reg_write(6'h08, 32'h0000_0100);
    check("R9 irq low after ack", {31'd0, irq}, 32'd0);

    // R8 set 1 unarmed
    send_frame(4, 3'b000, 8'd0, 8'd0, 32'h4000, 8'h22, 1'b0);
    reg_check(6'h24, 32'd1, "R8 missed");
    check("R8 irq", {31'd0, irq}, 32'd0);

    // R3 on second set
    reg_write(6'h18, 32'h0000_9800);
    send_frame(10, 3'b001, 8'd7, 8'd9, 32'h4000, 8'h33, 1'b1);
    reg_check(6'h14, 32'd7, "R5 set1 remaining");
    reg_write(6'h18, 32'h0000_0100);

    // R2 stop then R8 miss
    reg_write(6'h18, 32'h0000_1100);
    reg_check(6'h18, 32'h0, "R2 stopped");
    send_frame(3, 3'b000, 8'd0, 8'd0, 32'h4800, 8'h44, 1'b0);
    reg_check(6'h24, 32'd2, "R8 missed again");

    // R10 sof inside a frame
    reg_write(6'h18, 32'h0000_9800);
    for (int k = 0; k < 6; k++) push(32'h4810 + 32'(k), 8'h50 + 8'(k), "R10 partial");
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0) || (k == 6); rx_eof = 1'b0;
      rx_data = 8'h50 + 8'(k);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    repeat (6) @(negedge clk);
    reg_check(6'h20, 32'h2001, "R10 error status");
    check("R10 irq", {31'd0, irq}, 32'd1);
    reg_check(6'h14, 32'd7, "R10 buffer not consumed");
    send_frame(4, 3'b000, 8'd0, 8'd0, 32'h4800, 8'h66, 1'b0);
    reg_check(6'h24, 32'd2, "R10 not counted as missed");

    // R11 channel reset
    reg_write(6'h20, 32'h0000_8800);
    reg_check(6'h20, 32'h0, "R11 status cleared");
    check("R11 irq", {31'd0, irq}, 32'd0);
    reg_check(6'h18, 32'h0, "R11 disarmed");
    reg_check(6'h14, 32'd7, "R11 count kept");
    reg_check(6'h10, 32'h4000, "R11 base kept");
    reg_write(6'h08, 32'h0000_9800);
    send_frame(6, 3'b000, 8'd1, 8'd1, 32'h0000, 8'h77, 1'b1);
    reg_check(6'h04, 32'd7, "R11 set0 active again");

    repeat (4) @(negedge clk);
    check("R3 all expected writes seen", 32'(exp_addr.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule